// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets software read and write the 16-bit management registers of external Ethernet PHYs over a two-wire serial management bus. Software sees two 32-bit registers. The control/status word sits at byte offset 0 and the write-data word at byte offset 4. The block produces the management clock (MDC) from the system clock. It shifts out standard clause 22 frames on the MDIO line, and it samples the reply of the PHY on reads.

A transfer starts when software writes the control word with one of two command bits set. That bit then doubles as a busy flag: it reads back as set until the frame is finished, and the block clears it on its own. For a write, software first loads the write-data word. For a read, the returned value appears in the low half of the control word once the command bit has cleared. The register bus is a plain single-cycle port. Writes take effect on the clock edge and read data is combinational, so there is no back-pressure at the edge of the block. Software throttles itself by polling the command bits.

Top module: `mdio_master_regs`

## Requirements
- R1: After reset the control word and the write-data word read as zero, MDC is low and the MDIO output enable is low.
- R2: Offset 0 (address bit 2 clear) selects the control word and offset 4 (address bit 2 set) selects the write-data word. Only bits 15:0 of the write-data word are stored, and its bits 31:16 read as zero.
- R3: Writing the control word with bit 27 set while idle starts a write frame. Bit 27 reads 1 from the next cycle and clears by itself once the whole frame has been shifted out, within 66 MDC periods plus 8 clock cycles.
- R4: Writing the control word with bit 26 set while idle starts a read frame. Bit 26 reads 1 until the reply is captured, and then bits 15:0 of the control word hold the 16 bits the PHY returned, MSB first.
- R5: Every frame is sent MSB first in this order: 32 ones, the start code 01, the opcode (01 for write, 10 for read), the PHY address taken from control bits 20:16, and the register address taken from control bits 25:21. Bits 25:16 of the control word read back the last accepted addresses.
- R6: On a write frame the block drives the turnaround bits 1 then 0, followed by bits 15:0 of the write-data word, MSB first. On a read frame it releases MDIO (output enable low) for the two turnaround bits and the 16 data bits.
- R7: MDC toggles every DIV_HALF system clock cycles. The MDIO output changes only on the cycle when MDC falls, and MDIO input is sampled when MDC rises.
- R8: A write to the control word while a command bit is set is ignored. No further frame is sent, and the addresses and command bits are unchanged.
- R9: If one control write sets both bits 27 and 26, a read frame is sent and only bit 26 reads as set.
- R10: All PHY addresses 0 through 31 and all register addresses 0 through 31 are accepted and sent unchanged.
- R11: The output enable is low whenever no command bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W (3) | Byte address; bit 2 picks the word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; high drives the line |
| mdio_i | input | 1 | MDIO line value as seen by the block |

## Verification
A command bit is visible in the control word on the first cycle after the write edge. The bench reads it back one falling clock edge after the write. The bit then clears 64 MDC periods after the first MDC fall following the command, plus two clock cycles. The bench polls once per cycle and counts the cycles, so a clear that comes late fails a check. The PHY model in the bench samples each frame bit on the rising MDC edge and drives read data just after the falling edge, which is the edge on which the block shifts. Divider spacing and output timing are checked continuously on falling system clock edges, away from the edges where the design updates.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADR_W      = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADR_W + 2 + DATA_W;
  // first bit position at which a read frame releases the line
  localparam int RD_REL_IDX = PRE_BITS + 2 + 2 + 2 * ADR_W;
  localparam int CAP_IDX    = RD_REL_IDX + 2;

  localparam int CTL_WR_BIT  = 27;
  localparam int CTL_RD_BIT  = 26;
  localparam int CTL_REG_LSB = 21;
  localparam int CTL_PHY_LSB = 16;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ARM, SEQ_RUN} seq_state_t;

  typedef struct packed {
    logic              is_read;
    logic [ADR_W-1:0]  phy;
    logic [ADR_W-1:0]  regad;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic fall_tick,
  output logic rise_tick
);
  localparam int CW = (DIV_HALF > 2) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap      = (cnt_q == CW'(DIV_HALF - 1));
  assign fall_tick = wrap & mdc;
  assign rise_tick = wrap & ~mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_req_t         req,
  input  logic              fall_tick,
  input  logic              rise_tick,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  seq_state_t            state_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [FRAME_BITS-1:0] frame_d;
  logic [IDX_W-1:0]      idx_q;
  logic [IDX_W-1:0]      idx_nx;
  logic                  is_rd_q;
  logic [DATA_W-1:0]     shift_q;

  always_comb begin
    frame_d = {{PRE_BITS{1'b1}}, 2'b01,
               (req.is_read ? OP_RD : OP_WR),
               req.phy, req.regad,
               (req.is_read ? 2'b11 : 2'b10),
               (req.is_read ? {DATA_W{1'b0}} : req.wdata)};
  end

  assign idx_nx = idx_q + 1'b1;
  assign rdata  = shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      frame_q <= '0;
      idx_q   <= '0;
      is_rd_q <= 1'b0;
      shift_q <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            frame_q <= frame_d;
            is_rd_q <= req.is_read;
            state_q <= SEQ_ARM;
          end
        end
        SEQ_ARM: begin
          if (fall_tick) begin
            mdio_o  <= frame_q[FRAME_BITS-1];
            mdio_oe <= 1'b1;
            frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
            idx_q   <= '0;
            state_q <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (rise_tick && is_rd_q && (idx_q >= IDX_W'(CAP_IDX))) begin
            shift_q <= {shift_q[DATA_W-2:0], mdio_i};
          end
          if (fall_tick) begin
            if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
              mdio_oe <= 1'b0;
              done    <= 1'b1;
              state_q <= SEQ_IDLE;
            end else begin
              idx_q   <= idx_nx;
              mdio_o  <= frame_q[FRAME_BITS-1];
              frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
              mdio_oe <= !(is_rd_q && (idx_nx >= IDX_W'(RD_REL_IDX)));
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R8: the register side may only launch a frame while the shifter is idle
  p_start_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (state_q == SEQ_IDLE));

  // R6: the line is released from the turnaround to the end of a read frame
  p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_RUN && is_rd_q && rise_tick && idx_q >= IDX_W'(RD_REL_IDX)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              start,
  output mdio_req_t         req,
  input  logic              done,
  input  logic [DATA_W-1:0] rdata_in,
  output logic              busy
);
  localparam int SEL_BIT = 2;

  logic              wr_cmd_q, rd_cmd_q;
  logic [ADR_W-1:0]  phy_q, regad_q;
  logic [DATA_W-1:0] rdval_q, wdat_q;
  logic              ctl_sel, ctl_write;

  assign ctl_sel   = ~reg_addr[SEL_BIT];
  assign busy      = wr_cmd_q | rd_cmd_q;
  assign ctl_write = reg_we & ctl_sel & ~busy;
  assign start     = ctl_write & (reg_wdata[CTL_WR_BIT] | reg_wdata[CTL_RD_BIT]);

  assign req.is_read = reg_wdata[CTL_RD_BIT];
  assign req.phy     = reg_wdata[CTL_PHY_LSB +: ADR_W];
  assign req.regad   = reg_wdata[CTL_REG_LSB +: ADR_W];
  assign req.wdata   = wdat_q;

  always_comb begin
    reg_rdata = '0;
    if (ctl_sel) begin
      reg_rdata[CTL_WR_BIT]               = wr_cmd_q;
      reg_rdata[CTL_RD_BIT]               = rd_cmd_q;
      reg_rdata[CTL_REG_LSB +: ADR_W]     = regad_q;
      reg_rdata[CTL_PHY_LSB +: ADR_W]     = phy_q;
      reg_rdata[DATA_W-1:0]               = rdval_q;
    end else begin
      reg_rdata[DATA_W-1:0]               = wdat_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cmd_q <= 1'b0;
      rd_cmd_q <= 1'b0;
      phy_q    <= '0;
      regad_q  <= '0;
      rdval_q  <= '0;
      wdat_q   <= '0;
    end else begin
      if (ctl_write) begin
        phy_q    <= reg_wdata[CTL_PHY_LSB +: ADR_W];
        regad_q  <= reg_wdata[CTL_REG_LSB +: ADR_W];
        rd_cmd_q <= reg_wdata[CTL_RD_BIT];
        wr_cmd_q <= reg_wdata[CTL_WR_BIT] & ~reg_wdata[CTL_RD_BIT];
      end else if (done) begin
        wr_cmd_q <= 1'b0;
        rd_cmd_q <= 1'b0;
        if (rd_cmd_q) rdval_q <= rdata_in;
      end
      if (reg_we && !ctl_sel) wdat_q <= reg_wdata[DATA_W-1:0];
    end
  end

  // R9: at most one command is ever pending
  p_cmd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_cmd_q, rd_cmd_q}));

  // R3: a command bit clears only after the shifter reports completion
  p_clear_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  // R8: control writes during a transfer leave the addresses alone
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && ctl_sel) |=> ($stable(phy_q) && $stable(regad_q)));
endmodule

// File: rtl/mdio_master_regs.sv
module mdio_master_regs
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic              fall_tick, rise_tick;
  logic              start, done, busy;
  mdio_req_t         req;
  logic [DATA_W-1:0] seq_rdata;

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick)
  );

  mdio_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .start     (start),
    .req       (req),
    .done      (done),
    .rdata_in  (seq_rdata),
    .busy      (busy)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req       (req),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .rdata     (seq_rdata)
  );

  // R7: the data line moves only together with a falling management clock
  p_mdio_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc));

  // R11: nothing drives the line unless a command is pending
  p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

// File: tb/tb_mdio_master_regs.sv
module tb_mdio_master_regs;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 4;
  localparam int LIMIT      = 66 * 2 * DIV_HALF + 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_drv = 1'b1;

  int checks = 0;
  int fails  = 0;

  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  mdio_master_regs #(.DIV_HALF(DIV_HALF), .ADDR_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // PHY model: register storage and frame capture
  logic [15:0] mem [32][32];
  logic [63:0] cap_frame = '0;
  logic [63:0] cap_oe = '0;
  int          bidx = 0;
  bit          active = 0;
  int          frames_seen = 0;

  initial begin
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++)
        mem[p][r] = 16'((p * 1031 + r * 37 + 16'h1234) ^ (r << 9));
  end

  always @(posedge mdc) begin
    if (!active && mdio_oe) begin
      active = 1;
      bidx = 0;
    end
    if (active) begin
      cap_frame[63 - bidx] = mdio_i;
      cap_oe[63 - bidx]    = mdio_oe;
      bidx++;
      if (bidx == 64) begin
        active = 0;
        frames_seen++;
        if (cap_frame[29:28] == 2'b01)
          mem[cap_frame[27:23]][cap_frame[22:18]] = cap_frame[15:0];
      end
    end
  end

  always @(negedge mdc) begin
    if (active && cap_frame[29:28] == 2'b10 && bidx >= 48 && bidx < 64)
      phy_drv = mem[cap_frame[27:23]][cap_frame[22:18]][63 - bidx];
    else
      phy_drv = 1'b1;
  end

  // continuous timing monitor for R7
  int  half_viol = 0, edge_viol = 0, since = 0;
  bit  seen_tog = 0;
  logic prev_mdc = 1'b0, prev_o = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc != prev_mdc) begin
        if (seen_tog && since != DIV_HALF) half_viol++;
        since = 1;
        seen_tog = 1;
      end else begin
        since++;
      end
      if (mdio_o != prev_o && !(prev_mdc == 1'b1 && mdc == 1'b0)) edge_viol++;
    end
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, op, p, r, 2'b10, d};
  endfunction

  function automatic logic [31:0] ctl_word(input bit w, input bit rd,
                                           input logic [4:0] p, input logic [4:0] r);
    return (32'(w) << 27) | (32'(rd) << 26) | (32'(r) << 21) | (32'(p) << 16);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    for (int i = 0; i < 4 * LIMIT; i++) begin
      rd(3'd0, v);
      if (v[27:26] == 2'b00) break;
      cyc++;
    end
  endtask

  task automatic do_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    logic [31:0] v;
    int cyc;
    wr(3'd4, {16'hDEAD, d});
    wr(3'd0, ctl_word(1, 0, p, r));
    rd(3'd0, v);
    chk("R3 write busy bit set", 64'(v[27:26]), 64'(2'b10));
    wait_idle(cyc);
    chk("R3 write completes in time", 64'(cyc <= LIMIT), 64'd1);
    chk("R5 R6 write frame bits", cap_frame, exp_frame(2'b01, p, r, d));
    chk("R10 PHY stored value", 64'(mem[p][r]), 64'(d));
  endtask

  task automatic do_read(input logic [4:0] p, input logic [4:0] r);
    logic [31:0] v;
    int cyc;
    wr(3'd0, ctl_word(0, 1, p, r));
    rd(3'd0, v);
    chk("R4 read busy bit set", 64'(v[27:26]), 64'(2'b01));
    wait_idle(cyc);
    chk("R4 read completes in time", 64'(cyc <= LIMIT), 64'd1);
    rd(3'd0, v);
    chk("R4 read data returned", 64'(v[15:0]), 64'(mem[p][r]));
    chk("R5 read header bits", 64'(cap_frame[63:18]),
        64'(exp_frame(2'b10, p, r, 16'h0) >> 18));
    chk("R6 read release window", cap_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
    chk("R5 address readback", 64'(v[25:16]), 64'({r, p}));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc, base;
    void'($urandom(32'd2024));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v);
    chk("R1 control after reset", 64'(v), 64'd0);
    rd(3'd4, v);
    chk("R1 write-data after reset", 64'(v), 64'd0);
    chk("R1 output enable after reset", 64'(mdio_oe), 64'd0);

    // R2 write-data word keeps only the low half
    wr(3'd4, 32'hABCD_5A5A);
    rd(3'd4, v);
    chk("R2 write-data width", 64'(v), 64'h5A5A);
    rd(3'd0, v);
    chk("R2 control untouched by offset 4", 64'(v), 64'd0);

    // R10 address extremes
    do_write(5'd31, 5'd0, 16'h8001);
    do_read(5'd31, 5'd0);
    do_write(5'd0, 5'd31, 16'h7FFE);
    do_read(5'd0, 5'd31);
    do_read(5'd17, 5'd9);

    // R8 command during a transfer is ignored
    base = frames_seen;
    wr(3'd4, 32'h0000_C3C3);
    wr(3'd0, ctl_word(1, 0, 5'd3, 5'd4));
    wr(3'd0, ctl_word(0, 1, 5'd9, 5'd7));
    rd(3'd0, v);
    chk("R8 fields kept while busy", 64'(v[27:16]), 64'({2'b10, 5'd4, 5'd3}));
    wait_idle(cyc);
    repeat (LIMIT) @(negedge clk);
    chk("R8 single frame sent", 64'(frames_seen - base), 64'd1);
    chk("R8 frame is the first command", cap_frame, exp_frame(2'b01, 5'd3, 5'd4, 16'hC3C3));

    // R9 both command bits: read wins
    wr(3'd0, ctl_word(1, 1, 5'd5, 5'd6));
    rd(3'd0, v);
    chk("R9 only read bit set", 64'(v[27:26]), 64'(2'b01));
    wait_idle(cyc);
    rd(3'd0, v);
    chk("R9 opcode is read", 64'(cap_frame[29:28]), 64'(2'b10));
    chk("R9 read data", 64'(v[15:0]), 64'(mem[5][6]));

    // constrained random write/read pairs
    for (int k = 0; k < 16; k++) begin
      logic [4:0] p, r;
      logic [15:0] d;
      p = 5'($urandom % 32);
      r = 5'($urandom % 32);
      d = 16'($urandom);
      do_write(p, r, d);
      do_read(p, r);
    end

    // R11 idle line, R7 timing monitor
    chk("R11 released when idle", 64'(mdio_oe), 64'd0);
    chk("R7 MDC half period", 64'(half_viol), 64'd0);
    chk("R7 MDIO changes on MDC fall", 64'(edge_viol), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule